// File: doc/BRIEF.md
# Per-Block Write-Protection Lock Manager

This block keeps the write-protection state of every erase block in a flash array whose block count and block size are parameters. Software changes a block's protection with a two-write sequence on the command bus. The first write carries the arm code. The second write carries a lock, unlock or lock-down code, and its address selects the block. Each block holds two bits, locked and locked-down. Once a block is locked down, software cannot unlock it, and only reset returns it to the plain locked state.

The block serves two consumers. Identifier-mode reads use `rd_addr` and `rd_lock` to see any block's two state bits. The program/erase command controller presents its request on `op_go`, `op_erase` and `op_addr` and gets `op_refuse` back in the same cycle. A refused operation, and any wrong follow-up to the arm code, latch error flags that sit at the status-register positions of the wider device: lock error at bit 1, program error at bit 4, erase error at bit 5. A clear-status command on the same bus clears those flags.

Top module: `blk_lock_mgr`

## Requirements
- R1: A write of 0x60 while not armed arms the sequencer. The next write of any value disarms it, so a second follow-up write after that has no lock effect.
- R2: An armed follow-up of 0x01 sets locked on the block `cmd_addr >> BLK_SHIFT`. An armed follow-up of 0x2F sets both locked and locked-down on that block. The new state shows on `rd_lock` (bit 0 locked, bit 1 locked-down) from the cycle after the write, and no other block changes.
- R3: An armed follow-up of 0xD0 clears locked on the addressed block when that block is not locked down. When the block is locked down, the write has no effect.
- R4: An armed follow-up with any code other than 0x01, 0xD0 or 0x2F sets `sts_prog_err` and `sts_erase_err` from the next cycle and changes no block.
- R5: After reset every block reads locked=1 and locked-down=0, all three flags read 0, and the sequencer is not armed.
- R6: `op_refuse` equals `op_go` AND the locked bit of block `op_addr >> BLK_SHIFT`, in the same cycle. A refused program sets `sts_lock_err` and `sts_prog_err`. A refused erase (`op_erase`=1) sets `sts_lock_err` and `sts_erase_err`. These flags show from the next cycle, and a request that is not refused sets nothing.
- R7: A write of 0x50 while not armed clears all three flags from the next cycle. When a flag is set in the same cycle as the clear, the set wins.
- R8: Repeating a lock or a lock-down on a block already in that state changes nothing, and lock-down survives every command. Only reset clears it.
- R9: While not armed, writes of any code other than 0x60 and 0x50 change no block state and no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command write strobe, one write per cycle |
| cmd_addr | input | ADDR_W | Address of the command write |
| cmd_data | input | 8 | Command code |
| op_go | input | 1 | Controller requests a program or erase |
| op_erase | input | 1 | 1 = erase request, 0 = program request |
| op_addr | input | ADDR_W | Target address of the request |
| op_refuse | output | 1 | Request targets a locked block and must not start |
| rd_addr | input | ADDR_W | Identifier-read address |
| rd_lock | output | 2 | {locked-down, locked} of the block at rd_addr |
| sts_lock_err | output | 1 | Lock error flag (status bit 1) |
| sts_prog_err | output | 1 | Program error flag (status bit 4) |
| sts_erase_err | output | 1 | Erase error flag (status bit 5) |

## Verification
`op_refuse` and `rd_lock` are combinational, so they are due in the same cycle their inputs change. Block state and flags change on the clock edge that takes the write or request, so they are due one cycle after it. The bench drives every input on the falling edge. It checks combinational results 1 ns after driving, and it checks registered results on the falling edge that follows the capturing rising edge. Each sequence step is checked before the next write, so a consumed arm, an ignored unlock and a set-over-clear collision can each be seen on their own.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
    localparam logic [7:0] CODE_ARM    = 8'h60;
    localparam logic [7:0] CODE_LOCK   = 8'h01;
    localparam logic [7:0] CODE_UNLOCK = 8'hD0;
    localparam logic [7:0] CODE_DOWN   = 8'h2F;
    localparam logic [7:0] CODE_CLEAR  = 8'h50;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_LOCK,
        ACT_UNLOCK,
        ACT_DOWN
    } lock_act_e;

    typedef struct packed {
        logic lock_err;
        logic prog_err;
        logic erase_err;
    } err_flags_t;
endpackage

// File: rtl/blk_lock_seq.sv
module blk_lock_seq
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 8,
    localparam int BLK_W    = ADDR_W - BLK_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    output lock_act_e         act,
    output logic [BLK_W-1:0]  act_blk,
    output logic              seq_err,
    output logic              clr_req
);
    typedef struct packed {
        logic armed;
    } seq_st_t;

    seq_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        act     = ACT_NONE;
        seq_err = 1'b0;
        clr_req = 1'b0;
        act_blk = cmd_addr[ADDR_W-1:BLK_SHIFT];
        if (cmd_we) begin
            if (s_q.armed) begin
                s_d.armed = 1'b0;
                case (cmd_data)
                    CODE_LOCK:   act = ACT_LOCK;
                    CODE_UNLOCK: act = ACT_UNLOCK;
                    CODE_DOWN:   act = ACT_DOWN;
                    default:     seq_err = 1'b1;
                endcase
            end else if (cmd_data == CODE_ARM) begin
                s_d.armed = 1'b1;
            end else if (cmd_data == CODE_CLEAR) begin
                clr_req = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R1: the arm is consumed by the very next write
    p_arm_consumed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.armed && cmd_we) |=> !s_q.armed);

    // R1: only the arm code raises the armed state
    p_arm_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.armed) |-> ($past(cmd_we) && $past(cmd_data) == CODE_ARM));
endmodule

// File: rtl/blk_lock_bank.sv
module blk_lock_bank
    import blk_lock_pkg::*;
#(
    parameter int BLK_W   = 4,
    localparam int NUM_BLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  lock_act_e        act,
    input  logic [BLK_W-1:0] act_blk,
    input  logic [BLK_W-1:0] rd_blk,
    input  logic [BLK_W-1:0] op_blk,
    output logic [1:0]       rd_lock,
    output logic             op_locked
);
    typedef struct packed {
        logic [NUM_BLK-1:0] down;
        logic [NUM_BLK-1:0] lock;
    } bank_st_t;

    bank_st_t b_d, b_q;

    always_comb begin
        b_d = b_q;
        for (int i = 0; i < NUM_BLK; i++) begin
            if (act_blk == BLK_W'(i)) begin
                case (act)
                    ACT_LOCK:   b_d.lock[i] = 1'b1;
                    ACT_DOWN: begin
                        b_d.lock[i] = 1'b1;
                        b_d.down[i] = 1'b1;
                    end
                    ACT_UNLOCK: if (!b_q.down[i]) b_d.lock[i] = 1'b0;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            b_q.lock <= '1;
            b_q.down <= '0;
        end else begin
            b_q <= b_d;
        end
    end

    assign rd_lock   = {b_q.down[rd_blk], b_q.lock[rd_blk]};
    assign op_locked = b_q.lock[op_blk];

    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk_chk
        // R8: lock-down is never left while out of reset
        p_down_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            b_q.down[g] |=> b_q.down[g]);
        // R2: a locked-down block is always locked
        p_down_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
            b_q.down[g] |-> b_q.lock[g]);
        // R3: an unlock cannot open a locked-down block
        p_unlock_blocked_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (act == ACT_UNLOCK && act_blk == BLK_W'(g) && b_q.down[g]) |=> b_q.lock[g]);
        // R2: blocks not addressed keep their state
        p_other_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (act_blk != BLK_W'(g)) |=> ($stable(b_q.lock[g]) && $stable(b_q.down[g])));
    end
endmodule

// File: rtl/blk_lock_flags.sv
module blk_lock_flags
    import blk_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       seq_err,
    input  logic       refuse,
    input  logic       refuse_erase,
    input  logic       clr_req,
    output err_flags_t flags
);
    err_flags_t f_d, f_q;

    always_comb begin
        f_d = clr_req ? '0 : f_q;
        if (seq_err) begin
            f_d.prog_err  = 1'b1;
            f_d.erase_err = 1'b1;
        end
        if (refuse) begin
            f_d.lock_err = 1'b1;
            if (refuse_erase) f_d.erase_err = 1'b1;
            else              f_d.prog_err  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign flags = f_q;

    // R4: a bad follow-up raises both operation error flags
    p_seq_err_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |=> (f_q.prog_err && f_q.erase_err));

    // R7: a clear with no simultaneous set leaves every flag low
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !seq_err && !refuse) |=> (f_q == '0));

    // R9: flags only rise on a cause
    p_flag_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!seq_err && !refuse) |=> ($countones(f_q) <= $countones($past(f_q))));
endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int BLK_SHIFT = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              op_go,
    input  logic              op_erase,
    input  logic [ADDR_W-1:0] op_addr,
    output logic              op_refuse,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_lock,
    output logic              sts_lock_err,
    output logic              sts_prog_err,
    output logic              sts_erase_err
);
    localparam int BLK_W = ADDR_W - BLK_SHIFT;

    lock_act_e        act;
    logic [BLK_W-1:0] act_blk;
    logic             seq_err;
    logic             clr_req;
    logic             op_locked;
    err_flags_t       flags;

    blk_lock_seq #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_we   (cmd_we),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .act      (act),
        .act_blk  (act_blk),
        .seq_err  (seq_err),
        .clr_req  (clr_req)
    );

    blk_lock_bank #(.BLK_W(BLK_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .act_blk   (act_blk),
        .rd_blk    (rd_addr[ADDR_W-1:BLK_SHIFT]),
        .op_blk    (op_addr[ADDR_W-1:BLK_SHIFT]),
        .rd_lock   (rd_lock),
        .op_locked (op_locked)
    );

    assign op_refuse = op_go & op_locked;

    blk_lock_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .seq_err      (seq_err),
        .refuse       (op_refuse),
        .refuse_erase (op_erase),
        .clr_req      (clr_req),
        .flags        (flags)
    );

    assign sts_lock_err  = flags.lock_err;
    assign sts_prog_err  = flags.prog_err;
    assign sts_erase_err = flags.erase_err;

    // R6: a refused request always leaves the lock error flag set
    p_refuse_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_refuse |=> sts_lock_err);

    // R6: a refused erase flags erase, a refused program flags program
    p_refuse_kind_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_refuse |=> (op_erase ? sts_erase_err : sts_prog_err) == 1'b1 || $past(op_erase) != op_erase);
endmodule

// File: tb/blk_lock_mgr_test.sv
module blk_lock_mgr_test;
    localparam int ADDR_W    = 12;
    localparam int BLK_SHIFT = 8;
    localparam int NBLK      = 1 << (ADDR_W - BLK_SHIFT);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_we = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic [7:0]        cmd_data = '0;
    logic              op_go = 1'b0;
    logic              op_erase = 1'b0;
    logic [ADDR_W-1:0] op_addr = '0;
    logic              op_refuse;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [1:0]        rd_lock;
    logic              sts_lock_err, sts_prog_err, sts_erase_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    blk_lock_mgr #(.ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .op_go(op_go), .op_erase(op_erase),
        .op_addr(op_addr), .op_refuse(op_refuse), .rd_addr(rd_addr),
        .rd_lock(rd_lock), .sts_lock_err(sts_lock_err),
        .sts_prog_err(sts_prog_err), .sts_erase_err(sts_erase_err)
    );

    function automatic logic [ADDR_W-1:0] baddr(input int blk);
        return ADDR_W'((blk << BLK_SHIFT) | 8'h5A);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int blk, input logic [7:0] code);
        @(negedge clk);
        cmd_we = 1'b1; cmd_addr = baddr(blk); cmd_data = code;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int blk, input logic [1:0] exp);
        rd_addr = baddr(blk);
        #1;
        chk(tag, {6'd0, rd_lock}, {6'd0, exp});
    endtask

    task automatic flags_chk(input string tag, input logic [2:0] exp);
        #1;
        chk(tag, {5'd0, sts_lock_err, sts_prog_err, sts_erase_err}, {5'd0, exp});
    endtask

    task automatic t_reset_state;
        for (int b = 0; b < NBLK; b++) rd_chk("R5 reset block state", b, 2'b01);
        flags_chk("R5 reset flags", 3'b000);
    endtask

    task automatic t_unlock_and_lock;
        wr(3, 8'h60); wr(3, 8'hD0);
        rd_chk("R3 unlock block 3", 3, 2'b00);
        rd_chk("R2 neighbour block 2 untouched", 2, 2'b01);
        rd_chk("R1 arm consumed block 4 untouched", 4, 2'b01);
        wr(3, 8'h60); wr(3, 8'h01);
        rd_chk("R2 relock block 3", 3, 2'b01);
        wr(3, 8'h60); wr(3, 8'h01);
        rd_chk("R8 repeated lock unchanged", 3, 2'b01);
        flags_chk("R8 repeated lock no flags", 3'b000);
    endtask

    task automatic t_lockdown;
        wr(5, 8'h60); wr(5, 8'h2F);
        rd_chk("R2 lockdown block 5", 5, 2'b11);
        wr(5, 8'h60); wr(5, 8'hD0);
        rd_chk("R3 unlock ignored on locked-down", 5, 2'b11);
        wr(5, 8'h60); wr(5, 8'h2F);
        rd_chk("R8 repeated lockdown unchanged", 5, 2'b11);
        flags_chk("R3 no flags from ignored unlock", 3'b000);
    endtask

    task automatic t_bad_follow;
        wr(7, 8'h60); wr(7, 8'hD0);
        rd_chk("R3 unlock block 7", 7, 2'b00);
        wr(7, 8'h60); wr(7, 8'h20);
        flags_chk("R4 bad follow-up flags", 3'b011);
        rd_chk("R4 bad follow-up no block change", 7, 2'b00);
        wr(7, 8'h01);
        rd_chk("R1 second write after arm not a lock", 7, 2'b00);
        wr(7, 8'h2F);
        rd_chk("R9 unarmed lockdown code ignored", 7, 2'b00);
    endtask

    task automatic t_clear;
        wr(0, 8'h50);
        flags_chk("R7 clear flags", 3'b000);
        wr(0, 8'h60); wr(0, 8'h60);
        flags_chk("R4 arm code as follow-up is an error", 3'b011);
        rd_chk("R4 block 0 unchanged", 0, 2'b01);
        wr(0, 8'h50);
        flags_chk("R7 clear again", 3'b000);
    endtask

    task automatic t_refuse;
        @(negedge clk);
        op_go = 1'b1; op_erase = 1'b0; op_addr = baddr(0);
        #1; chk("R6 refuse program locked block", {7'd0, op_refuse}, 8'd1);
        @(negedge clk); op_go = 1'b0;
        flags_chk("R6 program refusal flags", 3'b110);
        wr(0, 8'h50);
        @(negedge clk);
        op_go = 1'b1; op_erase = 1'b1; op_addr = baddr(3);
        #1; chk("R6 refuse erase locked block", {7'd0, op_refuse}, 8'd1);
        @(negedge clk); op_go = 1'b0;
        flags_chk("R6 erase refusal flags", 3'b101);
        wr(0, 8'h50);
        @(negedge clk);
        op_go = 1'b1; op_erase = 1'b1; op_addr = baddr(7);
        #1; chk("R6 unlocked block accepted", {7'd0, op_refuse}, 8'd0);
        @(negedge clk); op_go = 1'b0;
        flags_chk("R6 accepted request sets nothing", 3'b000);
    endtask

    task automatic t_set_beats_clear;
        @(negedge clk);
        op_go = 1'b1; op_erase = 1'b0; op_addr = baddr(5);
        cmd_we = 1'b1; cmd_addr = baddr(0); cmd_data = 8'h50;
        @(negedge clk);
        op_go = 1'b0; cmd_we = 1'b0;
        flags_chk("R7 set wins over clear", 3'b110);
        wr(0, 8'h50);
        flags_chk("R7 clear after collision", 3'b000);
    endtask

    task automatic t_reset_clears_down;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        rd_chk("R8 reset clears lockdown", 5, 2'b01);
        rd_chk("R5 reset relocks block 7", 7, 2'b01);
        wr(5, 8'h60); wr(5, 8'hD0);
        rd_chk("R8 unlock works after reset", 5, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_unlock_and_lock();
        t_lockdown();
        t_bad_follow();
        t_clear();
        t_refuse();
        t_set_beats_clear();
        t_reset_clears_down();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule